// File: doc/BRIEF.md
# Iterative Multi-Cycle CORDIC Rotator

This block produces the cosine and sine of a signed angle with a sequential CORDIC engine in rotation mode. Each of its three working registers (x, y and residual angle) has a single adder/subtractor, and that adder is used again on every clock of an operation. A multiplexer in front of each register picks either the start values or the value fed back from the adder. An iteration counter sets the arithmetic right shift applied to x and y, and it also addresses a small table of arctangent constants. The sign bit of the residual angle chooses the rotation direction in each iteration.

A caller raises `start_i` for one cycle with the angle on `angle_i`. After twelve iterations the block pulses `done_o`, and `cos_o` and `sin_o` then hold the new results until the next pulse. Results go into their own output registers. This lets a new request presented during the final iteration cycle be loaded on the same edge that produces the previous result, so operations can run back to back without an idle cycle.

Top module: `cordic_iter_rotator`

## Requirements
- R1: After reset `done_o` is 0 and `cos_o` and `sin_o` are 0.
- R2: `angle_i` is a signed 12-bit two's-complement value, where 2048 counts equal pi radians. The operating range is -1024 to +1024, which is -pi/2 to +pi/2. The value on `angle_i` is taken on the edge that accepts `start_i`.
- R3: `cos_o` and `sin_o` are signed 16-bit two's-complement values, where 16384 equals 1.0. Each is within 40 LSB of the ideal cosine and sine of the accepted angle, including both range ends and negative angles.
- R4: `done_o` goes high for exactly one cycle, on the 12th rising edge after the edge that accepted `start_i`. It is low on edges 1 to 11.
- R5: A `start_i` pulse that arrives while an operation is in progress, in any cycle other than the final iteration cycle, is ignored. The running result, its timing and its value are unchanged, and no extra `done_o` pulse follows.
- R6: A `start_i` pulse in the final iteration cycle, which is the cycle before the edge that raises `done_o`, is accepted on that edge. Its own result appears 12 edges later, and the earlier result is still correct.
- R7: `cos_o` and `sin_o` change only on the edge that raises `done_o`, and keep their values at all other times.
- R8: While idle with `start_i` low, `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request; taken when idle or in the final iteration cycle |
| angle_i | input | 12 | Signed angle, 2048 counts = pi |
| done_o | output | 1 | One-cycle pulse when new results are on the outputs |
| cos_o | output | 16 | Signed cosine, 16384 = 1.0 |
| sin_o | output | 16 | Signed sine, 16384 = 1.0 |

## Verification
Two functions can fall in the same clock edge: producing the finished result and loading a new request. The bench provokes this by raising `start_i` in the final iteration cycle of one operation with a different angle. It then judges that the first pulse carries the first angle's cosine and sine and that a second pulse follows exactly 12 edges later with the second angle's values. A separate run raises `start_i` mid-operation and checks that neither the result nor the pulse timing moves. Accuracy is judged over every angle in the operating range.

// File: rtl/cordic_pkg.sv
package cordic_pkg;
  localparam int ANG_W    = 12;              // input angle width, pi = 2**(ANG_W-1)
  localparam int DATA_W   = 16;              // x/y width
  localparam int FRAC_W   = 14;              // x/y fraction bits, 1.0 = 2**FRAC_W
  localparam int Z_W      = 16;              // residual angle width, pi = 2**(Z_W-1)
  localparam int Z_SHIFT  = Z_W - ANG_W;
  localparam int MAX_ITER = 16;              // table depth

  // arctan(2**-i) scaled so that pi = 2**(Z_W-1)
  function automatic logic signed [Z_W-1:0] atan_entry(input int unsigned i);
    case (i)
      0:  return 16'sd8192;
      1:  return 16'sd4836;
      2:  return 16'sd2555;
      3:  return 16'sd1297;
      4:  return 16'sd651;
      5:  return 16'sd326;
      6:  return 16'sd163;
      7:  return 16'sd81;
      8:  return 16'sd41;
      9:  return 16'sd20;
      10: return 16'sd10;
      11: return 16'sd5;
      12: return 16'sd3;
      13: return 16'sd1;
      14: return 16'sd1;
      default: return 16'sd0;
    endcase
  endfunction
endpackage

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int ITER  = 12,
  parameter int CNT_W = $clog2(ITER)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ITER - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign last_o = busy_q && (cnt_q == LAST_CNT);
  assign load_o = start_i && (!busy_q || last_o);  // overlap load with finish
  assign step_o = busy_q;
  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= LAST_CNT));
  a_r4_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> done_o);
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o && start_i) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  a_r6_final_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && start_i) |=> (busy_q && cnt_q == '0 && done_o));
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> (!busy_q && !last_o));
endmodule

// File: rtl/cordic_branch.sv
module cordic_branch #(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                sub_i,
  input  logic signed [W-1:0] init_i,
  input  logic signed [W-1:0] opnd_i,
  output logic signed [W-1:0] q_o,
  output logic signed [W-1:0] nxt_o
);
  logic signed [W-1:0] q_q;

  assign nxt_o = sub_i ? (q_q - opnd_i) : (q_q + opnd_i);
  assign q_o   = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= init_i;
    else if (step_i) q_q <= nxt_o;
  end

  a_r2_load_takes_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(init_i)));
  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(q_o));
endmodule

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom
  import cordic_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0]      idx_i,
  output logic signed [Z_W-1:0] ang_o
);
  assign ang_o = atan_entry(int'(idx_i));
endmodule

// File: rtl/cordic_iter_rotator.sv
module cordic_iter_rotator
  import cordic_pkg::*;
#(
  parameter int ITER     = 12,   // at most MAX_ITER
  parameter int GAIN_INV = 9949  // 1/K for ITER iterations, 2**FRAC_W scale
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ANG_W-1:0]  angle_i,
  output logic              done_o,
  output logic [DATA_W-1:0] cos_o,
  output logic [DATA_W-1:0] sin_o
);
  localparam int CNT_W = $clog2(ITER);

  logic             load, step, last;
  logic [CNT_W-1:0] cnt;

  logic signed [DATA_W-1:0] x_q, y_q, x_nxt, y_nxt, x_sh, y_sh;
  logic signed [Z_W-1:0]    z_q, z_nxt, z_init, atan_c;
  logic signed [DATA_W-1:0] x_init, y_init;
  logic                     z_neg;
  logic signed [DATA_W-1:0] cos_q, sin_q;

  cordic_ctrl #(.ITER(ITER), .CNT_W(CNT_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .cnt_o  (cnt),
    .done_o (done_o)
  );

  cordic_atan_rom #(.CNT_W(CNT_W)) u_rom (
    .idx_i(cnt),
    .ang_o(atan_c)
  );

  assign z_neg  = z_q[Z_W-1];
  assign x_sh   = x_q >>> cnt;
  assign y_sh   = y_q >>> cnt;
  assign x_init = DATA_W'(GAIN_INV);
  assign y_init = '0;
  assign z_init = {angle_i, {Z_SHIFT{1'b0}}};

  // positive residual: rotate counter-clockwise
  cordic_branch #(.W(DATA_W)) u_x (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .sub_i(~z_neg), .init_i(x_init), .opnd_i(y_sh), .q_o(x_q), .nxt_o(x_nxt)
  );

  cordic_branch #(.W(DATA_W)) u_y (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .sub_i(z_neg), .init_i(y_init), .opnd_i(x_sh), .q_o(y_q), .nxt_o(y_nxt)
  );

  cordic_branch #(.W(Z_W)) u_z (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .sub_i(~z_neg), .init_i(z_init), .opnd_i(atan_c), .q_o(z_q), .nxt_o(z_nxt)
  );

  // results leave through their own registers so x/y can reload at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_q <= '0;
      sin_q <= '0;
    end else if (last) begin
      cos_q <= x_nxt;
      sin_q <= y_nxt;
    end
  end

  assign cos_o = cos_q;
  assign sin_o = sin_q;

  a_r7_outputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> ($stable(cos_o) && $stable(sin_o)));
  a_r7_update_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(cos_o) && $stable(sin_o)));
  a_r3_residual_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |-> ((z_nxt < 16'sd64) && (z_nxt > -16'sd64)));
endmodule

// File: tb/tb_cordic_iter_rotator.sv
module tb_cordic_iter_rotator;
  localparam int TOL = 40;
  localparam real PI = 3.141592653589793;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] angle_i = '0;
  logic        done_o;
  logic [15:0] cos_o, sin_o;

  int checks = 0;
  int errors = 0;
  int last_cos = 0;
  int last_sin = 0;

  always #5 clk_i = ~clk_i;

  cordic_iter_rotator dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .angle_i(angle_i),
    .done_o(done_o), .cos_o(cos_o), .sin_o(sin_o)
  );

  function automatic int ideal_cos(int a);
    return int'(16384.0 * $cos(real'(a) * PI / 2048.0));
  endfunction
  function automatic int ideal_sin(int a);
    return int'(16384.0 * $sin(real'(a) * PI / 2048.0));
  endfunction

  task automatic chk(string req, int act, int exp, int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic launch(int a);
    @(negedge clk_i);
    start_i = 1'b1;
    angle_i = 12'(a);
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // entered at the negedge after the accepting edge
  task automatic track(int a, int ign_k, int ign_a, bit nxt_en, int nxt_a, string req);
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (k < 12) begin
        chk({req, " R4 done low"}, int'(done_o), 0, 0);
        chk({req, " R7 cos hold"}, int'($signed(cos_o)), last_cos, 0);
        chk({req, " R7 sin hold"}, int'($signed(sin_o)), last_sin, 0);
      end else begin
        chk({req, " R4 done high"}, int'(done_o), 1, 0);
        chk({req, " R3 cos"}, int'($signed(cos_o)), ideal_cos(a), TOL);
        chk({req, " R3 sin"}, int'($signed(sin_o)), ideal_sin(a), TOL);
        last_cos = int'($signed(cos_o));
        last_sin = int'($signed(sin_o));
      end
      if (k == ign_k) begin
        start_i = 1'b1;
        angle_i = 12'(ign_a);
      end else if (k == 11 && nxt_en) begin
        start_i = 1'b1;
        angle_i = 12'(nxt_a);
      end else begin
        start_i = 1'b0;
      end
    end
  endtask

  task automatic idle_watch(int n, string req);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk({req, " done stays low"}, int'(done_o), 0, 0);
      chk({req, " cos unchanged"}, int'($signed(cos_o)), last_cos, 0);
    end
  endtask

  initial begin
    #1;
    chk("R1 done at reset", int'(done_o), 0, 0);
    chk("R1 cos at reset", int'(cos_o), 0, 0);
    chk("R1 sin at reset", int'(sin_o), 0, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 done after reset", int'(done_o), 0, 0);

    // R8: idle without request
    idle_watch(20, "R8");

    // R2 R3 R4: full sweep of the operating range, ends included
    for (int a = -1024; a <= 1024; a++) begin
      launch(a);
      track(a, -1, 0, 1'b0, 0, "R2 sweep");
    end

    // R5: mid-operation request ignored
    launch(300);
    track(300, 3, -700, 1'b0, 0, "R5 ignore");
    idle_watch(15, "R5");
    launch(-500);
    track(-500, 10, 900, 1'b0, 0, "R5 ignore late");
    idle_watch(15, "R5 late");

    // R6: back-to-back via final-cycle request
    launch(1000);
    track(1000, -1, 0, 1'b1, -1000, "R6 first");
    track(-1000, -1, 0, 1'b1, 0, "R6 second");
    track(0, -1, 0, 1'b0, 0, "R6 third");
    idle_watch(15, "R6 after");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule